// File: doc/BRIEF.md
# Reloadable Up-Down Counter

A synchronous binary counter of parameterised width (4 bits by default) that counts up or down one step per clock while enabled. A per-bit ripple chain of half adder/subtractor cells computes the next count. A 2-to-1 selector in front of each state bit chooses between that chain output and a parallel data word.

Every parallel load also records the loaded word as the start value. When the count reaches the end of its range while enabled, a comparator makes the next edge restore that start value instead of rolling over to zero. In the up direction the end of the range is all ones; in the down direction it is zero. A one-cycle wrap pulse marks each such restore.

An asynchronous clear forces both the count and the start value to zero at once, with no clock edge needed.

Top module: `updn_reload_counter`

## Requirements
- R1: While `clr` is 1, `count`, `wrap` and the stored start value are 0 immediately, without waiting for a clock edge.
- R2: When `load` is 1 at a rising edge, `count` takes `din` at that edge. Load overrides counting and the end-of-range restore.
- R3: Every load also stores `din` as the start value used by later restores.
- R4: With `load` 0 and `cnt_en` 0, `count` holds its value across the edge.
- R5: With `load` 0, `cnt_en` 1 and `down` 0, and `count` below all ones, `count` increases by one at the edge.
- R6: With `load` 0, `cnt_en` 1 and `down` 1, and `count` above zero, `count` decreases by one at the edge.
- R7: With `load` 0, `cnt_en` 1 and `down` 0, and `count` at all ones, the next edge sets `count` to the stored start value.
- R8: With `load` 0, `cnt_en` 1 and `down` 1, and `count` at zero, the next edge sets `count` to the stored start value.
- R9: `wrap` is 1 for exactly the cycle that follows an edge at which an R7 or R8 restore happened, and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Synchronous parallel load and start-value write |
| cnt_en | input | 1 | Count enable; carry-in of the lowest cell |
| down | input | 1 | Direction: 0 counts up, 1 counts down |
| din | input | W | Parallel data and start value |
| count | output | W | Current count |
| wrap | output | 1 | One-cycle pulse after an end-of-range restore |

## Verification
A corrupted start register stays hidden until the next end-of-range restore. It then appears at `count` one edge later, together with the `wrap` pulse, so the tests drive full runs to both ends of the range in both directions after each load. A fault in the ripple chain shows up as a wrong `count` on the first enabled edge whose carry or borrow reaches the faulty cell. Sweeping through every value in both directions therefore exposes it within one pass of the range. A clear that fails to act at once is caught part-way through the clock period, before the next edge could cover it up.

// File: rtl/updn_reload_counter.sv
`timescale 1ns/1ps
module updn_reload_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         load,
  input  logic         cnt_en,
  input  logic         down,
  input  logic [W-1:0] din,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] start_q;
  logic [W-1:0] sum;
  logic [W:0]   cy;
  logic [W-1:0] nxt;
  logic         at_end;
  logic         restore;

  assign cy[0] = cnt_en;

  for (genvar i = 0; i < W; i++) begin : g_cell
    assign sum[i]  = count[i] ^ cy[i];
    assign cy[i+1] = (down ^ count[i]) & cy[i];
  end

  assign at_end  = down ? (count == '0) : (count == TOP);
  assign restore = cnt_en & at_end;

  for (genvar i = 0; i < W; i++) begin : g_mux
    assign nxt[i] = load ? din[i] : (restore ? start_q[i] : sum[i]);
  end

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      count   <= '0;
      start_q <= '0;
      wrap    <= 1'b0;
    end else begin
      count <= nxt;
      wrap  <= ~load & restore;
      if (load) start_q <= din;
    end
  end
endmodule

// File: rtl/updn_reload_chk.sv
`timescale 1ns/1ps
module updn_reload_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clr,
  input logic         load,
  input logic         cnt_en,
  input logic         down,
  input logic [W-1:0] din,
  input logic [W-1:0] count,
  input logic         wrap,
  input logic [W-1:0] st,
  input logic         cy_top
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  // R1
  always @(negedge clk) begin
    if (clr) begin
      clr_zero_chk: assert (count == '0 && wrap == 1'b0 && st == '0);
    end
  end

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (clr)
    load |=> count == $past(din));

  // R3
  start_write_chk: assert property (@(posedge clk) disable iff (clr)
    load |=> st == $past(din));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && !cnt_en) |=> $stable(count));

  // R5
  up_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && cnt_en && !down && count != TOP) |=> count == $past(count) + 1'b1);

  // R6
  down_step_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && cnt_en && down && count != '0) |=> count == $past(count) - 1'b1);

  // R7
  up_restore_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && cnt_en && !down && count == TOP) |=> (count == $past(st) && wrap));

  // R8
  down_restore_chk: assert property (@(posedge clk) disable iff (clr)
    (!load && cnt_en && down && count == '0) |=> (count == $past(st) && wrap));

  // R9
  wrap_only_chk: assert property (@(posedge clk) disable iff (clr)
    !(!load && cy_top) |=> !wrap);
endmodule

bind updn_reload_counter updn_reload_chk #(.W(W)) u_chk (
  .clk(clk), .clr(clr), .load(load), .cnt_en(cnt_en), .down(down),
  .din(din), .count(count), .wrap(wrap), .st(start_q), .cy_top(cy[W])
);

// File: tb/test_updn_reload_counter.sv
`timescale 1ns/1ps
module test_updn_reload_counter;
  localparam int W = 4;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, clr = 1, load = 0, cnt_en = 0, down = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] count;
  logic wrap;

  int total = 0, bad = 0;
  int m_q = 0, m_st = 0;
  bit m_w = 0;
  string tag = "R1";
  bit done = 0;

  updn_reload_counter #(.W(W)) i_updn_reload_counter (
    .clk(clk), .clr(clr), .load(load), .cnt_en(cnt_en), .down(down),
    .din(din), .count(count), .wrap(wrap)
  );

  always #2 clk = ~clk;

  always @(posedge clk or posedge clr) begin
    if (clr) begin
      m_q = 0; m_st = 0; m_w = 0; tag = "R1";
    end else if (load) begin
      m_q = din; m_st = din; m_w = 0; tag = "R2";
    end else if (cnt_en && !down && m_q == MAXV) begin
      m_q = m_st; m_w = 1; tag = "R7";
    end else if (cnt_en && down && m_q == 0) begin
      m_q = m_st; m_w = 1; tag = "R8";
    end else if (cnt_en) begin
      m_q = down ? m_q - 1 : m_q + 1; m_w = 0; tag = down ? "R6" : "R5";
    end else begin
      m_w = 0; tag = "R4";
    end
  end

  task automatic check(input string t, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(tag, count, m_q);
      check("R9", wrap, m_w);
    end
  end

  task automatic step(input bit l, input bit e, input bit d, input int v);
    load = l; cnt_en = e; down = d; din = v[W-1:0];
    @(negedge clk);
  endtask

  initial begin
    #300000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1", count, 0);
    @(negedge clk);
    clr = 0;
    // R1 start value cleared: up run from 0 wraps to 0
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
    // R2 R3 load 5 then up through wrap (R7)
    step(1, 0, 0, 5);
    for (int i = 0; i < 14; i++) step(0, 1, 0, 0);
    // R4 hold
    for (int i = 0; i < 3; i++) step(0, 0, 0, 9);
    // R6 R8 down run with wrap to 5
    for (int i = 0; i < 10; i++) step(0, 1, 1, 0);
    // R2 load while counting
    step(1, 1, 0, 14);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    // direction change at boundaries
    step(1, 1, 1, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    step(1, 0, 0, 15);
    step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    // R2 load beats restore at end of range
    step(1, 1, 0, 3);
    step(1, 1, 0, 0);
    step(0, 1, 1, 0);
    // R1 clear mid-cycle
    step(1, 0, 0, 11);
    step(0, 1, 0, 0);
    #1 clr = 1;
    #0.5;
    check("R1", count, 0);
    check("R1", wrap, 0);
    @(negedge clk);
    clr = 0;
    for (int i = 0; i < 17; i++) step(0, 1, 0, 0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 6, r < 80, $urandom_range(0, 3) == 0 ? ~down : down, $urandom_range(0, MAXV));
      if (i % 700 == 350) begin
        #1 clr = 1;
        #0.5;
        check("R1", count, 0);
        @(negedge clk);
        clr = 0;
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule